// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block is the register side of a UART. It sits behind an APB slave port and offers four registers: data, status, control and a baud divisor. It also holds a small queue for received bytes. The serial shifter is a separate block. It hands bytes in over a valid/ready byte port and takes bytes to send from a one-cycle byte strobe.

Bytes that arrive while reception is switched on go into the queue. A read of the data register takes the oldest byte off the queue. A write to the data register sends its low byte out, but only while transmission is switched on. A single interrupt line gives a one-cycle pulse for each accepted byte and for each sent byte, and each of these two sources has its own enable.

The status word reports a fixed set of conditions:
- whether the queue holds data;
- whether the queue is at least half full;
- whether the queue is completely full;
- a sticky overrun flag;
- two transmit-side "empty" flags, which are always set, because there is no transmit buffering.

Top module: `uart_apb_regs`

## Requirements
- R1: After reset the control register reads 0x0000_0000, the status register reads 0x0000_0006 (bits 1 and 2 set, everything else clear), the receive queue is empty, and irq and tx_valid are low.
- R2: An APB transfer happens in a cycle where psel and penable are both high, and paddr[4:0] selects the register. Offset 0x00 is data, 0x04 is status, 0x08 is control and 0x0C is the divisor. In control, bits 0 to 12 and bit 31 can be written and all other bits read 0. The divisor keeps bits 11:0 and reads 0 above them. Offset 0x10 and every other offset read zero, and writes to them change nothing.
- R3: An offered byte (rx_valid and rx_ready both high) goes into the queue only while control bit 0 (receive on) is set. When bit 0 is clear, the byte is consumed and thrown away.
- R4: A read of the data register returns the oldest queued byte in prdata[7:0], with zeros above it, and removes that byte. A read of an empty queue returns 0. Status bit 0 is set exactly when the queue holds at least one byte.
- R5: A data-register write while control bit 1 (transmit on) is set raises tx_valid for one cycle, starting the cycle after the write, with tx_data equal to pwdata[7:0]. While bit 1 is clear, a data write produces no tx_valid.
- R6: irq is high for exactly the cycle after either of two events:
  - a byte is accepted into the queue while control bit 2 is set;
  - a byte is sent while control bit 3 is set.
  When both events fall in the same cycle they produce a single one-cycle pulse.
- R7: rx_ready is low exactly when the queue is full. If a byte is offered while reception is on and the queue is full, the byte is dropped and status bit 4 (overrun) is set. Bit 4 then stays set until reset.
- R8: Status bit 8 is set when the queue holds at least DEPTH/2 bytes. Status bit 10 is set when it holds DEPTH bytes. Writes to the status register have no effect.
- R9: Bytes leave the queue in the order they arrived. A pop and a push in the same cycle are both carried out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 5 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| rx_valid | input | 1 | Byte offered by receiver |
| rx_data | input | 8 | Offered byte |
| rx_ready | output | 1 | Queue can take a byte |
| tx_valid | output | 1 | One-cycle send strobe |
| tx_data | output | 8 | Byte to send |
| irq | output | 1 | Interrupt pulse |

## Verification
The hardest cases to reach from the ports are a pop and a push in the same cycle, and an overrun at the exact moment the queue becomes full. To reach them, the bench includes a task that holds rx_valid high during the access phase of a data read. It also fills the queue to DEPTH and keeps offering bytes until the dropped byte sets the overrun flag. A random phase then mixes control changes, sends, reads and offers. Throughout the run, a queue-based model is compared against every output on every clock.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam logic [4:0] OFF_DATA = 5'h00;
  localparam logic [4:0] OFF_STAT = 5'h04;
  localparam logic [4:0] OFF_CTRL = 5'h08;
  localparam logic [4:0] OFF_DIV  = 5'h0C;

  // control bit positions
  localparam int CB_RX_ON  = 0;
  localparam int CB_TX_ON  = 1;
  localparam int CB_RX_IE  = 2;
  localparam int CB_TX_IE  = 3;

  // status bit positions
  localparam int SB_DRDY   = 0;
  localparam int SB_TSEMP  = 1;
  localparam int SB_TFEMP  = 2;
  localparam int SB_OVR    = 4;
  localparam int SB_RHALF  = 8;
  localparam int SB_RFULL  = 10;

  localparam logic [31:0] CTRL_WMASK = 32'h8000_1FFF;
  localparam int DIV_W = 12;

  typedef struct packed {
    logic rx_on;
    logic tx_on;
    logic rx_ie;
    logic tx_ie;
  } ctl_view_t;

  function automatic ctl_view_t ctl_view(input logic [31:0] c);
    ctl_view_t v;
    v.rx_on = c[CB_RX_ON];
    v.tx_on = c[CB_TX_ON];
    v.rx_ie = c[CB_RX_IE];
    v.tx_ie = c[CB_TX_IE];
    return v;
  endfunction

  function automatic logic [31:0] status_word(input int unsigned occ,
                                              input int unsigned depth,
                                              input logic ovr);
    logic [31:0] s;
    s = '0;
    s[SB_DRDY]  = (occ != 0);
    s[SB_TSEMP] = 1'b1;
    s[SB_TFEMP] = 1'b1;
    s[SB_OVR]   = ovr;
    s[SB_RHALF] = (occ >= depth / 2);
    s[SB_RFULL] = (occ == depth);
    return s;
  endfunction
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_stage.sv
module uart_tx_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [DW-1:0] byte_in,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= fire;
      if (fire) tx_data <= byte_in;
    end
  end
endmodule

// File: rtl/uart_evt_pulse.sv
module uart_evt_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_evt,
  input  logic rx_ie,
  input  logic tx_evt,
  input  logic tx_ie,
  output logic irq
);
  logic hit;
  assign hit = (rx_evt && rx_ie) || (tx_evt && tx_ie);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= hit;
  end
endmodule

// File: rtl/uart_apb_regs.sv
module uart_apb_regs
  import uart_regs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [4:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]      ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             ovr_q;
  ctl_view_t        cv;

  logic acc_wr, acc_rd;
  logic hit_data, hit_stat, hit_ctrl, hit_div;

  // named internal events
  logic rx_push, rx_pop, rx_drop, tx_fire;

  logic [7:0]    fifo_head;
  logic [CW-1:0] fifo_count;
  logic          fifo_full, fifo_empty;
  logic [31:0]   stat_w;

  assign cv       = ctl_view(ctrl_q);
  assign acc_wr   = psel && penable && pwrite;
  assign acc_rd   = psel && penable && !pwrite;
  assign hit_data = (paddr == OFF_DATA);
  assign hit_stat = (paddr == OFF_STAT);
  assign hit_ctrl = (paddr == OFF_CTRL);
  assign hit_div  = (paddr == OFF_DIV);

  assign rx_ready = !fifo_full;
  assign rx_push  = rx_valid && rx_ready && cv.rx_on;
  assign rx_drop  = rx_valid && fifo_full && cv.rx_on;
  assign rx_pop   = acc_rd && hit_data && !fifo_empty;
  assign tx_fire  = acc_wr && hit_data && cv.tx_on;

  assign stat_w = status_word(32'(fifo_count), DEPTH, ovr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (acc_wr && hit_ctrl) ctrl_q <= pwdata & CTRL_WMASK;
      if (acc_wr && hit_div)  div_q  <= pwdata[DIV_W-1:0];
      if (rx_drop)            ovr_q  <= 1'b1;
    end
  end

  always_comb begin
    prdata = '0;
    unique case (1'b1)
      hit_data: prdata = {24'h0, fifo_head};
      hit_stat: prdata = stat_w;
      hit_ctrl: prdata = ctrl_q;
      hit_div:  prdata = {{(32-DIV_W){1'b0}}, div_q};
      default:  prdata = '0;
    endcase
  end

  uart_rx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .wdata (rx_data),
    .pop   (rx_pop),
    .head  (fifo_head),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  uart_tx_stage #(.DW(8)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (tx_fire),
    .byte_in  (pwdata[7:0]),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  uart_evt_pulse u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_evt (rx_push),
    .rx_ie  (cv.rx_ie),
    .tx_evt (tx_fire),
    .tx_ie  (cv.tx_ie),
    .irq    (irq)
  );
endmodule

// File: rtl/uart_apb_regs_chk.sv
module uart_apb_regs_chk #(
  parameter int DEPTH = 16,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          tx_fire,
  input logic          rx_ready,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_count,
  input logic          ovr_q,
  input logic [31:0]   ctrl_q,
  input logic          tx_valid,
  input logic          irq
);
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_push || tx_fire)); // R6
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(ctrl_q[1])); // R5
  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> ctrl_q[0]); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !rx_ready && !rx_push); // R7
  AST_POP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_push) |=> fifo_count == $past(fifo_count) - 1'b1); // R4
  AST_BOTH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_push) |=> $stable(fifo_count)); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q); // R7
endmodule

bind uart_apb_regs uart_apb_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_push    (rx_push),
  .rx_pop     (rx_pop),
  .tx_fire    (tx_fire),
  .rx_ready   (rx_ready),
  .fifo_full  (fifo_full),
  .fifo_count (fifo_count),
  .ovr_q      (ovr_q),
  .ctrl_q     (ctrl_q),
  .tx_valid   (tx_valid),
  .irq        (irq)
);

// File: tb/uart_apb_regs_bench.sv
`timescale 1ns/1ps
module uart_apb_regs_bench;
  localparam int D = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [4:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic rx_valid = 0;
  logic [7:0] rx_data = '0, tx_data;
  logic rx_ready, tx_valid, irq;

  always #5 clk = ~clk;

  uart_apb_regs #(.DEPTH(D)) u_uart_apb_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .irq(irq)
  );

  // behavioural reference model
  logic [7:0]  q[$];
  logic [31:0] m_ctrl;
  logic [11:0] m_div;
  bit m_ovr, m_irq, m_txv;
  logic [7:0] m_txd;
  int n_checks = 0, n_err = 0;
  string phase = "R1 reset";
  bit done = 0;

  function automatic logic [31:0] m_status();
    logic [31:0] s = 32'h6;
    s[0]  = q.size() != 0;
    s[4]  = m_ovr;
    s[8]  = q.size() >= D / 2;
    s[10] = q.size() == D;
    return s;
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00:   return (q.size() != 0) ? {24'h0, q[0]} : 32'h0;
      5'h04:   return m_status();
      5'h08:   return m_ctrl;
      5'h0C:   return {20'h0, m_div};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ctrl = 0; m_div = 0; m_ovr = 0; m_irq = 0; m_txv = 0; m_txd = 0;
    end else begin
      logic [31:0] c_old;
      bit full_old, rx_ev, tx_ev;
      c_old = m_ctrl; full_old = (q.size() == D); rx_ev = 0; tx_ev = 0;
      m_txv = 0;
      if (psel && penable && pwrite) begin
        if (paddr == 5'h00 && c_old[1]) begin m_txv = 1; m_txd = pwdata[7:0]; tx_ev = 1; end
        if (paddr == 5'h08) m_ctrl = pwdata & 32'h8000_1FFF;
        if (paddr == 5'h0C) m_div = pwdata[11:0];
      end
      if (psel && penable && !pwrite && paddr == 5'h00 && q.size() != 0) void'(q.pop_front());
      if (rx_valid && c_old[0]) begin
        if (full_old) m_ovr = 1;
        else begin q.push_back(rx_data); rx_ev = 1; end
      end
      m_irq = (rx_ev && c_old[2]) || (tx_ev && c_old[3]);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R6 irq", {31'h0, irq}, {31'h0, m_irq});
      chk("R5 tx_valid", {31'h0, tx_valid}, {31'h0, m_txv});
      if (m_txv) chk("R5 tx_data", {24'h0, tx_data}, {24'h0, m_txd});
      chk("R7 rx_ready", {31'h0, rx_ready}, {31'h0, (q.size() < D)});
      if (psel && penable && !pwrite) begin
        case (paddr)
          5'h00:   chk("R4 data read", prdata, m_read(paddr));
          5'h04:   chk("R8 status read", prdata, m_read(paddr));
          default: chk("R2 register read", prdata, m_read(paddr));
        endcase
      end
    end
  end

  task automatic apb(input bit wr, input logic [4:0] a, input logic [31:0] d, input bit push = 0,
                     input logic [7:0] b = 0);
    @(negedge clk); psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; rx_valid = push; rx_data = b;
    @(negedge clk); psel = 0; penable = 0; rx_valid = 0;
  endtask

  task automatic offer(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1 reset values";
    apb(0, 5'h04, 0); apb(0, 5'h08, 0); apb(0, 5'h00, 0);
    phase = "R2 map";
    apb(1, 5'h08, 32'hFFFF_FFFF); apb(0, 5'h08, 0);
    apb(1, 5'h0C, 32'hFFFF_FABC); apb(0, 5'h0C, 0);
    apb(1, 5'h10, 32'h1234_5678); apb(0, 5'h10, 0); apb(0, 5'h14, 0); apb(0, 5'h06, 0);
    apb(1, 5'h08, 32'h0);
    phase = "R3 receive off";
    offer(8'hA1); offer(8'hA2); apb(0, 5'h04, 0); apb(0, 5'h00, 0);
    phase = "R6 rx irq";
    apb(1, 5'h08, 32'h5);
    offer(8'h11); offer(8'h22); offer(8'h33);
    phase = "R9 order";
    apb(0, 5'h00, 0); apb(0, 5'h00, 0, 1, 8'h44); apb(0, 5'h00, 0); apb(0, 5'h00, 0);
    phase = "R4 empty read";
    apb(0, 5'h00, 0); apb(0, 5'h04, 0);
    phase = "R5 send off";
    apb(1, 5'h00, 32'h55); 
    phase = "R5 send on";
    apb(1, 5'h08, 32'h3); apb(1, 5'h00, 32'hFFFF_FF5A);
    phase = "R6 joint";
    apb(1, 5'h08, 32'hF); apb(1, 5'h00, 32'h77, 1, 8'h66); apb(0, 5'h00, 0);
    phase = "R8 fill";
    for (int i = 0; i < D; i++) begin offer(8'(i + 8'h80)); apb(0, 5'h04, 0); end
    phase = "R7 overrun";
    offer(8'hEE); apb(0, 5'h04, 0); apb(1, 5'h04, 32'h0); apb(0, 5'h04, 0);
    apb(0, 5'h00, 0, 1, 8'hEF); apb(0, 5'h04, 0);
    for (int i = 0; i < D; i++) apb(0, 5'h00, 0);
    apb(0, 5'h04, 0);
    phase = "R9 random";
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 7);
      case (op)
        0: apb(1, 5'h08, {28'h0, 4'($urandom)});
        1: apb(1, 5'h00, $urandom);
        2: apb(0, 5'h00, 0);
        3: apb(0, 5'h04, 0);
        4: offer(8'($urandom));
        5: apb(0, 5'h00, 0, 1, 8'($urandom));
        6: apb(1, 5'h0C, $urandom);
        default: apb(0, 5'($urandom_range(0, 31)), 0);
      endcase
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_err++;
      $display("FAIL watchdog [%s] actual=hung expected=finished", phase);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule